// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block is the clock-master serial audio output of a multichannel audio processor. It sends eight processed channels as four stereo pairs, one pair on each data line, and drives a bit clock and a word clock that all four lines share. The system supplies a clock enable, `bit_tick`. Each tick moves the bit clock through one half period.

A 4-bit format code selects the number of bit clocks per frame (64, 48 or 32) and the framing: I2S, left-justified, or right-justified at 24, 20, 18 or 16 bits. A separate bit sends every word LSB first instead of MSB first. A mapping stage picks the processing channel that feeds each output slot. The format code, bit order and mapping are all captured at the start of each frame, so a change never breaks a frame that is in progress.

Samples arrive as one frame of eight words over a valid/ready handshake into a one-deep holding register:
- `s_ready` is high exactly while the holding register is empty.
- An accepted frame moves into the transmit bank at the next frame start.
- If no frame is waiting at a frame start, that frame sends silence.
- The producer may hold `s_valid` and its data for as long as it likes. Nothing is lost while `s_ready` is low.

Top module: `serial_audio_tx`

## Requirements
- R1: Data line `sdo[l]` carries output slot 2l in the left half-frame and slot 2l+1 in the right half-frame. Slot k takes its sample from the processing channel named by `slot_map[3k+2:3k]`. Channel c is `s_samples[24c+23:24c]`.
- R2: Each `bit_tick` cycle toggles `bclk` while the block is enabled, and `bclk` holds otherwise. `wclk` and `sdo` change only as `bclk` falls.
- R3: At 64 bit clocks per frame, the code selects the format as follows: 0000 is I2S, 0001 is left-justified 24-bit, and 0010, 0011, 0100 and 0101 are right-justified 24, 20, 18 and 16-bit.
- R4: At 48 bit clocks per frame, the code selects the format as follows: 1110 is I2S and 1010, 1011, 1100 and 1101 are right-justified 24, 20, 18 and 16-bit. I2S bits that would run past the 24-slot half-frame are dropped.
- R5: At 32 bit clocks per frame, 0111 is I2S with 16-bit words and 1111 is justified 16-bit data. Only the 16 most significant sample bits are sent.
- R6: In I2S the word clock is low for the left half and the first data bit follows the word-clock edge by one bit clock. In the justified formats the word clock is high for the left half and data starts at the half-frame edge, unless R7 moves it.
- R7: In right-justified formats the last data bit sits in the last slot of the half-frame and the leading unused slots are 0. Words narrower than 24 bits take the most significant sample bits.
- R8: With `lsb_first`=1 the same bits go out in reverse order within the same slots.
- R9: After reset, and on the cycle after `tx_off` is sampled high, `bclk`, `wclk` and `sdo` are all 0. Re-enabling starts a fresh frame.
- R10: `s_ready` equals "holding register empty". An accepted frame is sent in the next frame. A frame that starts with nothing pending sends all-zero data.
- R11: Codes 0110, 1000 and 1001 behave as 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Half-bit-clock enable |
| tx_off | input | 1 | Stops all serial output when high |
| fmt_code | input | 4 | Clock ratio and framing code |
| lsb_first | input | 1 | 1 = least significant bit first |
| slot_map | input | 24 | Eight 3-bit source-channel fields |
| s_valid | input | 1 | Sample frame valid |
| s_ready | output | 1 | Holding register empty |
| s_samples | input | 192 | Eight 24-bit samples |
| bclk | output | 1 | Bit clock |
| wclk | output | 1 | Word clock |
| sdo | output | 4 | Serial data, one line per pair |

## Verification
The bench builds the block with its defaults: 24-bit samples, four lines and 3-bit mapping fields. With these values the bench can reach every defined format code, all three frame ratios and their half-frame truncation, and every right-justified zero-fill width. A reference model in the bench predicts each bit-clock slot on all four lines, so mapping permutations and repeated sources, reversed bit order and the silence of a frame with no input pending are each compared slot by slot.

// File: rtl/satx_pkg.sv
package satx_pkg;
  typedef enum logic [1:0] {FR_I2S = 2'd0, FR_LEFT = 2'd1, FR_RIGHT = 2'd2} frame_kind_e;

  typedef struct packed {
    logic [6:0]  ratio;
    frame_kind_e kind;
    logic [4:0]  width;
  } frame_fmt_t;

  function automatic frame_fmt_t decode_fmt(input logic [3:0] code);
    frame_fmt_t f;
    f = '{ratio: 7'd64, kind: FR_I2S, width: 5'd24};
    case (code)
      4'b0001: f = '{ratio: 7'd64, kind: FR_LEFT,  width: 5'd24};
      4'b0010: f = '{ratio: 7'd64, kind: FR_RIGHT, width: 5'd24};
      4'b0011: f = '{ratio: 7'd64, kind: FR_RIGHT, width: 5'd20};
      4'b0100: f = '{ratio: 7'd64, kind: FR_RIGHT, width: 5'd18};
      4'b0101: f = '{ratio: 7'd64, kind: FR_RIGHT, width: 5'd16};
      4'b1110: f = '{ratio: 7'd48, kind: FR_I2S,   width: 5'd24};
      4'b1010: f = '{ratio: 7'd48, kind: FR_RIGHT, width: 5'd24};
      4'b1011: f = '{ratio: 7'd48, kind: FR_RIGHT, width: 5'd20};
      4'b1100: f = '{ratio: 7'd48, kind: FR_RIGHT, width: 5'd18};
      4'b1101: f = '{ratio: 7'd48, kind: FR_RIGHT, width: 5'd16};
      4'b0111: f = '{ratio: 7'd32, kind: FR_I2S,   width: 5'd16};
      4'b1111: f = '{ratio: 7'd32, kind: FR_LEFT,  width: 5'd16};
      default: f = '{ratio: 7'd64, kind: FR_I2S,   width: 5'd24};
    endcase
    return f;
  endfunction
endpackage

// File: rtl/satx_bit_timer.sv
module satx_bit_timer #(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             tx_off,
  input  logic [POS_W-1:0] last_pos,
  output logic             bclk,
  output logic             fall,
  output logic             frame_start,
  output logic [POS_W-1:0] nxt_pos
);
  logic [POS_W-1:0] pos_q;
  logic             wrap;

  assign fall        = bit_tick && bclk && !tx_off;
  assign wrap        = pos_q >= last_pos;
  assign frame_start = fall && wrap;
  assign nxt_pos     = wrap ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || tx_off) begin
      bclk  <= 1'b0;
      pos_q <= '1;
    end else if (bit_tick) begin
      bclk <= ~bclk;
      if (bclk) pos_q <= nxt_pos;
    end
  end
endmodule

// File: rtl/satx_sample_bank.sv
module satx_sample_bank #(
  parameter int SAMPLE_W = 24,
  parameter int N_CH     = 8,
  localparam int BUS_W   = SAMPLE_W * N_CH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [BUS_W-1:0] s_samples,
  input  logic             frame_start,
  output logic [BUS_W-1:0] bank_nxt
);
  logic [BUS_W-1:0] hold_q, bank_q;
  logic             full_q;

  assign s_ready  = !full_q;
  assign bank_nxt = frame_start ? (full_q ? hold_q : '0) : bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      bank_q <= '0;
      full_q <= 1'b0;
    end else begin
      bank_q <= bank_nxt;
      if (s_valid && !full_q) begin
        hold_q <= s_samples;
        full_q <= 1'b1;
      end else if (frame_start) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/satx_slot_bit.sv
module satx_slot_bit
  import satx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  localparam int IDX_W   = $clog2(SAMPLE_W)
) (
  input  logic [SAMPLE_W-1:0] word,
  input  frame_kind_e         kind,
  input  logic [4:0]          width,
  input  logic [6:0]          half,
  input  logic [6:0]          slot,
  input  logic                lsb_first,
  output logic                bit_o
);
  int               start_slot, j;
  logic [IDX_W-1:0] idx;

  always_comb begin
    case (kind)
      FR_I2S:   start_slot = 1;
      FR_RIGHT: start_slot = int'(half) - int'(width);
      default:  start_slot = 0;
    endcase
    j     = int'(slot) - start_slot;
    idx   = '0;
    bit_o = 1'b0;
    if (j >= 0 && j < int'(width)) begin
      if (lsb_first) idx = IDX_W'(SAMPLE_W - int'(width) + j);
      else           idx = IDX_W'(SAMPLE_W - 1 - j);
      bit_o = word[idx];
    end
  end
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import satx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int N_LINES  = 4,
  localparam int N_CH    = 2 * N_LINES,
  localparam int MAP_W   = $clog2(N_CH),
  localparam int POS_W   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_tick,
  input  logic                     tx_off,
  input  logic [3:0]               fmt_code,
  input  logic                     lsb_first,
  input  logic [N_CH*MAP_W-1:0]    slot_map,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic [N_CH*SAMPLE_W-1:0] s_samples,
  output logic                     bclk,
  output logic                     wclk,
  output logic [N_LINES-1:0]       sdo
);
  frame_fmt_t                fmt_q, fmt_n;
  logic                      lsb_q, lsb_n;
  logic [N_CH*MAP_W-1:0]     map_q, map_n;
  logic [N_CH*SAMPLE_W-1:0]  bank_n;
  logic                      fall, frame_start;
  logic [POS_W-1:0]          nxt_pos, half, slot;
  logic                      right;
  logic [N_LINES-1:0]        sdo_n;

  satx_bit_timer #(.POS_W(POS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_off(tx_off),
    .last_pos(fmt_q.ratio - 7'd1), .bclk(bclk), .fall(fall),
    .frame_start(frame_start), .nxt_pos(nxt_pos)
  );

  satx_sample_bank #(.SAMPLE_W(SAMPLE_W), .N_CH(N_CH)) u_bank (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_samples(s_samples), .frame_start(frame_start), .bank_nxt(bank_n)
  );

  assign fmt_n = frame_start ? decode_fmt(fmt_code) : fmt_q;
  assign lsb_n = frame_start ? lsb_first : lsb_q;
  assign map_n = frame_start ? slot_map : map_q;
  assign half  = fmt_n.ratio >> 1;
  assign right = nxt_pos >= half;
  assign slot  = right ? nxt_pos - half : nxt_pos;

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic [MAP_W-1:0]    src;
    logic [SAMPLE_W-1:0] word;
    assign src  = right ? map_n[(2*l+1)*MAP_W +: MAP_W] : map_n[(2*l)*MAP_W +: MAP_W];
    assign word = bank_n[src*SAMPLE_W +: SAMPLE_W];
    satx_slot_bit #(.SAMPLE_W(SAMPLE_W)) u_bit (
      .word(word), .kind(fmt_n.kind), .width(fmt_n.width), .half(half),
      .slot(slot), .lsb_first(lsb_n), .bit_o(sdo_n[l])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q <= decode_fmt(4'b0000);
      lsb_q <= 1'b0;
      map_q <= '0;
      wclk  <= 1'b0;
      sdo   <= '0;
    end else if (tx_off) begin
      wclk <= 1'b0;
      sdo  <= '0;
    end else if (fall) begin
      fmt_q <= fmt_n;
      lsb_q <= lsb_n;
      map_q <= map_n;
      wclk  <= (fmt_n.kind == FR_I2S) ? right : !right;
      sdo   <= sdo_n;
    end
  end
endmodule

// File: rtl/serial_audio_tx_chk.sv
module serial_audio_tx_chk #(
  parameter int N_LINES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bit_tick,
  input logic               tx_off,
  input logic               s_valid,
  input logic               s_ready,
  input logic               bclk,
  input logic               wclk,
  input logic [N_LINES-1:0] sdo
);
  AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !tx_off) |=> (bclk != $past(bclk))); // R2
  AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !tx_off) |=> $stable(bclk)); // R2
  AST_RISE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> ($stable(sdo) && $stable(wclk))); // R2
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_off |=> (!bclk && !wclk && sdo == '0)); // R9
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready); // R10
endmodule

bind serial_audio_tx serial_audio_tx_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_off(tx_off),
  .s_valid(s_valid), .s_ready(s_ready), .bclk(bclk), .wclk(wclk), .sdo(sdo)
);

// File: tb/tb_serial_audio_tx.sv
module tb_serial_audio_tx;
  logic         clk = 0, rst_n = 0, bit_tick = 0, tx_off = 0;
  logic [3:0]   fmt_code = 0;
  logic         lsb_first = 0;
  logic [23:0]  slot_map = 0;
  logic         s_valid = 0, s_ready;
  logic [191:0] s_samples = 0;
  logic         bclk, wclk;
  logic [3:0]   sdo;

  int checks = 0, fails = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic       prev_bclk = 0;

  serial_audio_tx dut (.*);

  always #2.5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    bit_tick <= ~bit_tick;
  end

  // monitor: compare every falling bit-clock edge against the queue
  initial forever begin
    @(negedge clk);
    if (prev_bclk && !bclk && exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({wclk, sdo} !== e) begin
        fails++;
        $display("FAIL %s: wclk/sdo actual %b expected %b", t, {wclk, sdo}, e);
      end
    end
    prev_bclk = bclk;
  end

  function automatic logic ref_bit(input logic [23:0] smp, input logic [3:0] code,
                                   input logic lsb, input int s, input int half);
    int kind, w, st, j;
    kind = 0; w = 24;
    case (code)
      4'b0001: kind = 1;
      4'b0010, 4'b1010: begin kind = 2; w = 24; end
      4'b0011, 4'b1011: begin kind = 2; w = 20; end
      4'b0100, 4'b1100: begin kind = 2; w = 18; end
      4'b0101, 4'b1101: begin kind = 2; w = 16; end
      4'b0111: w = 16;
      4'b1111: begin kind = 1; w = 16; end
      default: ;
    endcase
    st = (kind == 0) ? 1 : (kind == 2) ? half - w : 0;
    j = s - st;
    if (j < 0 || j >= w) return 1'b0;
    return lsb ? smp[24 - w + j] : smp[23 - j];
  endfunction

  function automatic int ratio_of(input logic [3:0] code);
    case (code)
      4'b1110, 4'b1010, 4'b1011, 4'b1100, 4'b1101: return 48;
      4'b0111, 4'b1111: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic push_frame(input logic [3:0] code, input logic lsb, input logic [23:0] mp,
                            input logic [191:0] smp, input string tag);
    int r, half;
    r = ratio_of(code);
    half = r / 2;
    for (int p = 0; p < r; p++) begin
      logic rt, wc;
      logic [3:0] d;
      int s;
      rt = p >= half;
      s = rt ? p - half : p;
      wc = (code == 4'b0111 || code == 4'b1110 || ratio_of(code) == 64 &&
            !(code inside {4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101})) ? rt : !rt;
      for (int l = 0; l < 4; l++) begin
        int sl, ch;
        sl = 2 * l + (rt ? 1 : 0);
        ch = int'(mp[3*sl +: 3]);
        d[l] = ref_bit(smp[24*ch +: 24], code, lsb, s, half);
      end
      exp_q.push_back({wc, d});
      tag_q.push_back(tag);
    end
  endtask

  task automatic run_case(input logic [3:0] code, input logic lsb, input logic [23:0] mp,
                          input logic [191:0] smp, input bit underrun, input string tag);
    @(negedge clk); tx_off = 1;
    @(negedge clk); @(negedge clk);
    checks++;
    if ({bclk, wclk, sdo} !== 6'b0) begin
      fails++;
      $display("FAIL R9 off: actual %b expected 000000", {bclk, wclk, sdo});
    end
    fmt_code = code; lsb_first = lsb; slot_map = mp;
    while (!s_ready) @(negedge clk);
    s_valid = 1; s_samples = smp;
    @(negedge clk); s_valid = 0;
    push_frame(code, lsb, mp, smp, tag);
    if (underrun) push_frame(code, lsb, mp, '0, "R10 underrun silence");
    tx_off = 0;
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  function automatic logic [191:0] mk_samples(input int seed);
    logic [191:0] v;
    for (int c = 0; c < 8; c++)
      v[24*c +: 24] = 24'(32'h00A5C3F1 * (seed + c + 1) ^ (32'h5A17 << c));
    return v;
  endfunction

  localparam logic [23:0] IDENT = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
  localparam logic [23:0] PERM  = {3'd2, 3'd2, 3'd0, 3'd7, 3'd1, 3'd4, 3'd6, 3'd5};

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if ({bclk, wclk, sdo, s_ready} !== 7'b0000001) begin
      fails++;
      $display("FAIL R9 reset: actual %b expected 0000001", {bclk, wclk, sdo, s_ready});
    end
    run_case(4'b0000, 0, IDENT, mk_samples(1), 1, "R3 R6 R1 R10 i2s64");
    run_case(4'b0001, 0, IDENT, mk_samples(2), 0, "R3 R6 left64");
    run_case(4'b0010, 0, IDENT, mk_samples(3), 0, "R3 R7 right24");
    run_case(4'b0011, 0, IDENT, mk_samples(4), 0, "R3 R7 right20");
    run_case(4'b0100, 0, IDENT, mk_samples(5), 0, "R3 R7 right18");
    run_case(4'b0101, 0, IDENT, mk_samples(6), 0, "R3 R7 right16");
    run_case(4'b1110, 0, IDENT, mk_samples(7), 0, "R4 R6 i2s48");
    run_case(4'b1010, 0, IDENT, mk_samples(8), 0, "R4 right24_48");
    run_case(4'b1011, 0, IDENT, mk_samples(9), 0, "R4 R7 right20_48");
    run_case(4'b1100, 0, IDENT, mk_samples(10), 0, "R4 R7 right18_48");
    run_case(4'b1101, 0, IDENT, mk_samples(11), 0, "R4 R7 right16_48");
    run_case(4'b0111, 0, IDENT, mk_samples(12), 0, "R5 i2s32");
    run_case(4'b1111, 0, IDENT, mk_samples(13), 0, "R5 just32");
    run_case(4'b0011, 1, IDENT, mk_samples(14), 0, "R8 lsb right20");
    run_case(4'b0000, 1, IDENT, mk_samples(15), 0, "R8 lsb i2s64");
    run_case(4'b0001, 0, PERM,  mk_samples(16), 0, "R1 permuted map");
    run_case(4'b1000, 0, IDENT, mk_samples(17), 0, "R11 unlisted code");
    run_case(4'b0110, 0, PERM,  mk_samples(18), 1, "R11 R10 unlisted underrun");
    @(negedge clk); tx_off = 1;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule